// File: doc/BRIEF.md
# PF Identity Restore Sequencer

After a function level reset, the PCIe core puts a physical function's configuration register 0 (vendor and device ID) back to its power-on value. The value programmed at boot is not loaded again. A host that reads the register once the reset window has closed would then see the wrong identity. This block is a hardware sequencer that runs alongside the core and keeps the identity for two physical functions. It watches three inputs: the link-training state carried in a debug word, the per-function stop-request bits that the core raises on reset entry, and a free-running microsecond timebase. When a reset starts, it reads and keeps the programmed identity. It then waits out the reset window. Finally it compares the live register against the kept value and writes the identity back where the two differ. In the same step it clears that function's stop-request bit.

Configuration space is reached through a command port. The port carries a 64-bit word with the target address in the upper half and the data in the lower half, and takes a single acknowledge per access. The address selects the function in bits 31:24 of the address half, with register offset 0. The block starts an evaluation pass itself, at most once per 100 µs of timebase. Within a pass it handles function 0 first, then function 1, and it never has more than one access in flight.

Top module: `pf_id_restore`

## Requirements
- R1: A pass takes action only when the 6-bit link-state field at bits 8:3 of `dbg_word` equals 0x11. Every other bit of `dbg_word` is ignored. With any other value the pass ends with no configuration access and no stop-clear pulse.
- R2: When both `stop_req` bits are 0 at the start of a pass, the pass ends with no configuration access and no stop-clear pulse.
- R3: When a function's stop bit (bit 0 for function 0, bit 1 for function 1) is set and no identity is kept for it (kept value zero), the block issues a read. The read word has `cfg_write`=0, bits 63:32 equal to the function number shifted left by 24, and bits 31:0 zero. The block keeps the returned 32 bits. If the read returns zero, the read is repeated on the next pass.
- R4: A kept identity survives later reset events without being read again, and is cleared only by `rst_n`.
- R5: On the first pass that sees a function's stop bit, the block records the current timebase as that function's start and marks the function active. An active function is re-read only once the elapsed time is strictly greater than 99,700 µs. At exactly 99,700 µs there is no access.
- R6: If that re-read differs from the kept identity, `stop_clr` pulses for one cycle with a 1 in only that function's bit. The next access is a write of the kept identity to the same address. When the write completes, the function is no longer active.
- R7: If the re-read equals the kept identity, nothing is written, the stop bit is left alone, and the function stays active, so it is re-read on the next pass.
- R8: Within one pass, function 0 is handled before function 1, both for capture and for restore.
- R9: Only one access is outstanding at a time. `cfg_req`, `cfg_write` and `cfg_word` stay steady until the cycle in which `cfg_ack` is high, and `cfg_req` falls in the following cycle.
- R10: The first pass after reset starts at once. After that, a pass starts only when the timebase has advanced by at least 100 µs since the previous pass started.
- R11: While `rst_n` is low, `cfg_req`, `cfg_write`, `cfg_word` and `stop_clr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_us | input | 64 | Free-running microsecond timebase |
| dbg_word | input | 64 | Debug data word; link-training state in bits 8:3 |
| stop_req | input | 2 | Per-function stop-request bits from the core |
| stop_clr | output | 2 | One-cycle pulse, 1 in the bit of the function whose stop bit is to be cleared |
| cfg_req | output | 1 | Configuration access request, held until acknowledged |
| cfg_write | output | 1 | 1 for write, 0 for read |
| cfg_word | output | 64 | Address in bits 63:32, write data in bits 31:0 |
| cfg_ack | input | 1 | Access complete; read data valid in the same cycle |
| cfg_rdata | input | 32 | Read data |

## Verification
The bench targets the elapsed-time boundary. A re-read must not happen at exactly 99,700 µs but must happen 100 µs later; a compare written as greater-or-equal would restore one pass too early. It also sets the two stop bits together so that both functions restore in the same pass. Write order and the stop-clear-before-write ordering are then checked: a design that swapped the functions or skipped the clear leaves a stop bit set or writes in the wrong order. The bench also covers a matching re-read, where a design that always writes would clear the stop bit too soon. Further cases are a capture that returns zero and must be retried, a block reset that must discard the kept identities, a timebase step under 100 µs that must not start a pass, and a link-state value that differs only in bits outside 8:3.

// File: rtl/flr_pkg.sv
// Shared types for the PF identity restore sequencer.
// Assumes: the sequencer states are few enough to fit three bits.
package flr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,  // waiting for the next pass
        ST_CAP      = 3'd1,  // arm and decide on capture for current PF
        ST_CAP_WAIT = 3'd2,  // capture read outstanding
        ST_CHK      = 3'd3,  // decide on expiry re-read for current PF
        ST_CHK_WAIT = 3'd4,  // expiry re-read outstanding
        ST_WB       = 3'd5,  // issue identity write-back
        ST_WB_WAIT  = 3'd6   // write-back outstanding
    } seq_state_e;

endpackage

// File: rtl/flr_cfg_port.sv
// Configuration command port: turns a one-cycle start into a request that
// is held until acknowledged. Assumes the caller starts only when idle.
module flr_cfg_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int WORD_W = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic              req,
    output logic              write,
    output logic [WORD_W-1:0] word,
    output logic              done
);

    // Completion is the acknowledged cycle of a live request.
    assign done = req && ack;

    // Hold the request and its word until the acknowledge arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req   <= 1'b0;
            write <= 1'b0;
            word  <= '0;
        end else if (done) begin
            req <= 1'b0;
        end else if (start && !req) begin
            req   <= 1'b1;
            write <= is_write;
            word  <= {addr, wdata};
        end
    end

endmodule

// File: rtl/flr_pf_slot.sv
// Per-function record: active mark, start timestamp and kept identity.
// Assumes the timebase wraps only after far longer than the wait window.
module flr_pf_slot #(
    parameter int          TS_W    = 64,
    parameter int          ID_W    = 32,
    parameter longint      WAIT_US = 99700
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now,
    input  logic            arm,
    input  logic            disarm,
    input  logic            load,
    input  logic [ID_W-1:0] load_val,
    output logic            active,
    output logic [ID_W-1:0] saved,
    output logic            expired
);

    localparam logic [TS_W-1:0] WAIT_LIM = TS_W'(WAIT_US);

    logic [TS_W-1:0] start_ts;

    // Track the active mark and the timestamp taken when it was set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            start_ts <= '0;
        end else if (disarm) begin
            active <= 1'b0;
        end else if (arm && !active) begin
            active   <= 1'b1;
            start_ts <= now;
        end
    end

    // Keep the captured identity until block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved <= '0;
        end else if (load) begin
            saved <= load_val;
        end
    end

    // Window has passed only when strictly longer than the limit.
    assign expired = active && ((now - start_ts) > WAIT_LIM);

endmodule

// File: rtl/pf_id_restore.sv
// PF identity restore sequencer. Runs an evaluation pass per timebase
// interval; captures each function's config register 0 when its stop bit
// appears, and after the reset window writes it back if the live value
// differs, clearing the stop bit just before the write.
// Assumes: the responder acknowledges every request; NUM_PF <= 256.
module pf_id_restore #(
    parameter int          NUM_PF    = 2,
    parameter int          TS_W      = 64,
    parameter int          ID_W      = 32,
    parameter int          DBG_W     = 64,
    parameter int          LS_LSB    = 3,
    parameter int          LS_W      = 6,
    parameter logic [5:0]  LS_ACTIVE = 6'h11,
    parameter longint      WAIT_US   = 99700,
    parameter longint      PASS_US   = 100,
    localparam int         PF_W      = (NUM_PF > 1) ? $clog2(NUM_PF) : 1,
    localparam int         ADDR_W    = 32,
    localparam int         WORD_W    = ADDR_W + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_us,
    input  logic [DBG_W-1:0]  dbg_word,
    input  logic [NUM_PF-1:0] stop_req,
    output logic [NUM_PF-1:0] stop_clr,
    output logic              cfg_req,
    output logic              cfg_write,
    output logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_ack,
    input  logic [ID_W-1:0]   cfg_rdata
);
    import flr_pkg::*;

    localparam logic [TS_W-1:0] PASS_GAP = TS_W'(PASS_US);
    localparam logic [PF_W-1:0] LAST_PF  = PF_W'(NUM_PF - 1);

    seq_state_e        state_q, state_d;
    logic [PF_W-1:0]   pf_q, pf_d;
    logic [NUM_PF-1:0] stop_q;
    logic [TS_W-1:0]   last_pass;
    logic              pass_seen;

    logic              pass_due, pass_take, in_link;
    logic              arm_en, load_en, disarm_en;
    logic              port_start, port_wr, port_done;
    logic [NUM_PF-1:0] clr_d;
    logic [ADDR_W-1:0] port_addr;
    logic [ID_W-1:0]   port_data;

    logic              slot_active  [NUM_PF];
    logic              slot_expired [NUM_PF];
    logic [ID_W-1:0]   slot_saved   [NUM_PF];

    // Link-state field compare and pass cadence.
    assign in_link  = (dbg_word[LS_LSB +: LS_W] == LS_ACTIVE);
    assign pass_due = !pass_seen || ((time_us - last_pass) >= PASS_GAP);

    // One record per function.
    for (genvar g = 0; g < NUM_PF; g++) begin : g_slot
        flr_pf_slot #(
            .TS_W    (TS_W),
            .ID_W    (ID_W),
            .WAIT_US (WAIT_US)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .now      (time_us),
            .arm      (arm_en    && (pf_q == PF_W'(g))),
            .disarm   (disarm_en && (pf_q == PF_W'(g))),
            .load     (load_en   && (pf_q == PF_W'(g))),
            .load_val (cfg_rdata),
            .active   (slot_active[g]),
            .saved    (slot_saved[g]),
            .expired  (slot_expired[g])
        );
    end

    // Address of config register 0 for the current function.
    assign port_addr = ADDR_W'(pf_q) << 24;
    assign port_data = port_wr ? slot_saved[pf_q] : '0;

    flr_cfg_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (ID_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (port_start),
        .is_write (port_wr),
        .addr     (port_addr),
        .wdata    (port_data),
        .ack      (cfg_ack),
        .req      (cfg_req),
        .write    (cfg_write),
        .word     (cfg_word),
        .done     (port_done)
    );

    // Next-state and strobe decode of the pass sequencer.
    always_comb begin
        state_d    = state_q;
        pf_d       = pf_q;
        pass_take  = 1'b0;
        arm_en     = 1'b0;
        load_en    = 1'b0;
        disarm_en  = 1'b0;
        port_start = 1'b0;
        port_wr    = 1'b0;
        clr_d      = '0;
        case (state_q)
            ST_IDLE: begin
                if (pass_due) begin
                    pass_take = 1'b1;
                    if (in_link && (|stop_req)) begin
                        state_d = ST_CAP;
                        pf_d    = '0;
                    end
                end
            end
            ST_CAP: begin
                arm_en = stop_q[pf_q];
                if (stop_q[pf_q] && (slot_saved[pf_q] == '0)) begin
                    port_start = 1'b1;
                    state_d    = ST_CAP_WAIT;
                end else if (pf_q == LAST_PF) begin
                    pf_d    = '0;
                    state_d = ST_CHK;
                end else begin
                    pf_d = pf_q + 1'b1;
                end
            end
            ST_CAP_WAIT: begin
                if (port_done) begin
                    load_en = 1'b1;
                    if (pf_q == LAST_PF) begin
                        pf_d    = '0;
                        state_d = ST_CHK;
                    end else begin
                        pf_d    = pf_q + 1'b1;
                        state_d = ST_CAP;
                    end
                end
            end
            ST_CHK: begin
                if (slot_expired[pf_q]) begin
                    port_start = 1'b1;
                    state_d    = ST_CHK_WAIT;
                end else if (pf_q == LAST_PF) begin
                    state_d = ST_IDLE;
                end else begin
                    pf_d = pf_q + 1'b1;
                end
            end
            ST_CHK_WAIT: begin
                if (port_done) begin
                    if (cfg_rdata != slot_saved[pf_q]) begin
                        clr_d[pf_q] = 1'b1;
                        state_d     = ST_WB;
                    end else if (pf_q == LAST_PF) begin
                        state_d = ST_IDLE;
                    end else begin
                        pf_d    = pf_q + 1'b1;
                        state_d = ST_CHK;
                    end
                end
            end
            ST_WB: begin
                port_start = 1'b1;
                port_wr    = 1'b1;
                state_d    = ST_WB_WAIT;
            end
            ST_WB_WAIT: begin
                port_wr = 1'b1;
                if (port_done) begin
                    disarm_en = 1'b1;
                    if (pf_q == LAST_PF) begin
                        state_d = ST_IDLE;
                    end else begin
                        pf_d    = pf_q + 1'b1;
                        state_d = ST_CHK;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers and the registered stop-clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pf_q     <= '0;
            stop_clr <= '0;
        end else begin
            state_q  <= state_d;
            pf_q     <= pf_d;
            stop_clr <= clr_d;
        end
    end

    // Pass bookkeeping: timestamp of the last pass and stop snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pass <= '0;
            pass_seen <= 1'b0;
            stop_q    <= '0;
        end else if (pass_take) begin
            last_pass <= time_us;
            pass_seen <= 1'b1;
            stop_q    <= stop_req;
        end
    end

endmodule

// File: rtl/flr_restore_chk.sv
// Protocol checker for pf_id_restore, attached by bind below.
// Assumes the default two-function configuration.
module flr_restore_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  stop_clr,
    input logic        cfg_req,
    input logic        cfg_write,
    input logic [63:0] cfg_word,
    input logic        cfg_ack
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_word) && $stable(cfg_write))); // R9

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_ack) |=> !cfg_req); // R9

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stop_clr)); // R6

    AST_CLR_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_req) && cfg_write) |-> ($past(stop_clr) != 2'b00)); // R6

    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ((cfg_word[63:57] == 7'd0) && (cfg_word[55:32] == 24'd0))); // R3

    AST_RD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_write) |-> (cfg_word[31:0] == 32'd0)); // R3

    AST_CLR_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clr != 2'b00) |-> !cfg_req); // R9

endmodule

bind pf_id_restore flr_restore_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_clr  (stop_clr),
    .cfg_req   (cfg_req),
    .cfg_write (cfg_write),
    .cfg_word  (cfg_word),
    .cfg_ack   (cfg_ack)
);

// File: tb/pf_id_restore_tb.sv
// Bench for pf_id_restore: a config-space and stop-bit model, a vector
// table of passes, then directed reset and cadence tests.
module pf_id_restore_tb;

    localparam logic [31:0] ID0 = 32'h9702_177D;
    localparam logic [31:0] ID1 = 32'h9703_177D;
    localparam logic [31:0] IDZ = 32'h9700_177D;

    typedef struct packed {
        logic [5:0]  ls;
        logic [1:0]  set_stop;
        logic [1:0]  force_rst;
        logic [31:0] t;
        logic [1:0]  exp_stop;
        logic [31:0] exp_id0;
        logic [31:0] exp_id1;
        logic [7:0]  exp_rd;
        logic [7:0]  exp_wr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{6'h11, 2'b00, 2'b00, 32'd1000,   2'b00, ID0, ID1, 8'd0, 8'd0}, // R2
        '{6'h05, 2'b01, 2'b00, 32'd1100,   2'b01, ID0, ID1, 8'd0, 8'd0}, // R1
        '{6'h11, 2'b00, 2'b00, 32'd1200,   2'b01, ID0, ID1, 8'd1, 8'd0}, // R3
        '{6'h11, 2'b00, 2'b01, 32'd100900, 2'b01, IDZ, ID1, 8'd1, 8'd0}, // R5
        '{6'h11, 2'b00, 2'b00, 32'd101000, 2'b00, ID0, ID1, 8'd2, 8'd1}, // R6
        '{6'h11, 2'b10, 2'b00, 32'd200000, 2'b10, ID0, ID1, 8'd3, 8'd1}, // R3
        '{6'h11, 2'b00, 2'b00, 32'd299800, 2'b10, ID0, ID1, 8'd4, 8'd1}, // R7
        '{6'h11, 2'b00, 2'b10, 32'd299900, 2'b00, ID0, ID1, 8'd5, 8'd2}, // R7
        '{6'h11, 2'b11, 2'b11, 32'd400000, 2'b11, IDZ, IDZ, 8'd5, 8'd2}, // R4
        '{6'h05, 2'b00, 2'b00, 32'd600000, 2'b11, IDZ, IDZ, 8'd5, 8'd2}, // R1
        '{6'h11, 2'b00, 2'b00, 32'd600100, 2'b00, ID0, ID1, 8'd7, 8'd4}, // R8
        '{6'h11, 2'b00, 2'b00, 32'd700000, 2'b00, ID0, ID1, 8'd7, 8'd4}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_us = '0;
    logic [63:0] dbg_word = '0;
    logic [1:0]  stop_req = '0;
    logic [1:0]  stop_clr;
    logic        cfg_req, cfg_write;
    logic [63:0] cfg_word;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    // Injection requests from the stimulus process.
    logic        apply = 1'b0;
    logic [1:0]  inj_stop = '0;
    logic [1:0]  inj_force = '0;
    logic [31:0] inj_val = '0;

    // Model state.
    logic [31:0] mem [2];
    int          rd_cnt = 0, wr_cnt = 0, ord_err = 0, fmt_err = 0;
    logic [3:0]  wr_hist = '0;
    int          n_chk = 0, n_bad = 0;
    bit          done_flag = 1'b0;

    always #2 clk = ~clk;

    pf_id_restore u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .time_us   (time_us),
        .dbg_word  (dbg_word),
        .stop_req  (stop_req),
        .stop_clr  (stop_clr),
        .cfg_req   (cfg_req),
        .cfg_write (cfg_write),
        .cfg_word  (cfg_word),
        .cfg_ack   (cfg_ack),
        .cfg_rdata (cfg_rdata)
    );

    initial begin
        mem[0] = ID0;
        mem[1] = ID1;
    end

    // Core and config-space model, away from the active edge.
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (stop_clr[i]) stop_req[i] = 1'b0;
        end
        if (apply) begin
            stop_req = stop_req | inj_stop;
            for (int i = 0; i < 2; i++) begin
                if (inj_force[i]) mem[i] = inj_val;
            end
        end
        if (cfg_req && !cfg_ack) begin
            cfg_ack = 1'b1;
            if (cfg_word[63:57] != 0 || cfg_word[55:32] != 0) fmt_err++;
            if (cfg_write) begin
                mem[cfg_word[56]] = cfg_word[31:0];
                wr_cnt++;
                wr_hist = {wr_hist[2:0], cfg_word[56]};
                if (stop_req[cfg_word[56]]) ord_err++;
            end else begin
                if (cfg_word[31:0] != 0) fmt_err++;
                cfg_rdata = mem[cfg_word[56]];
                rd_cnt++;
            end
        end else begin
            cfg_ack = 1'b0;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic inject(input logic [1:0] s, input logic [1:0] f, input logic [31:0] v);
        @(posedge clk); #1;
        inj_stop = s; inj_force = f; inj_val = v; apply = 1'b1;
        @(posedge clk); #1;
        apply = 1'b0;
    endtask

    task automatic set_pass(input logic [5:0] ls, input logic [31:0] t);
        @(posedge clk); #1;
        dbg_word = 64'hFFFF_0000_0000_0207 | (64'(ls) << 3);
        time_us  = 64'(t);
        repeat (40) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // Stimulus and checks.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 req in reset", cfg_req, 0);
        check("R11 clr in reset", stop_clr, 0);
        check("R11 word in reset", cfg_word, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        for (int v = 0; v < NV; v++) begin
            inject(VEC[v].set_stop, VEC[v].force_rst, IDZ);
            set_pass(VEC[v].ls, VEC[v].t);
            check($sformatf("R1/R2/R6 stop v%0d", v), stop_req, VEC[v].exp_stop);
            check($sformatf("R6 id0 v%0d", v), mem[0], VEC[v].exp_id0);
            check($sformatf("R6 id1 v%0d", v), mem[1], VEC[v].exp_id1);
            check($sformatf("R3/R5/R7 reads v%0d", v), rd_cnt, VEC[v].exp_rd);
            check($sformatf("R6/R7 writes v%0d", v), wr_cnt, VEC[v].exp_wr);
            if (v == 10) check("R8 write order PF0 then PF1", wr_hist[1:0], 2'b01);
        end
        check("R6 clear before write", ord_err, 0);
        check("R3 access word format", fmt_err, 0);

        // Block reset discards kept identities; zero capture retried.
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        inject(2'b01, 2'b01, 32'd0);
        set_pass(6'h11, 32'd700050);
        check("R10 no pass inside 100us", rd_cnt, 7);
        set_pass(6'h11, 32'd700100);
        check("R4 reset clears kept id, capture read", rd_cnt, 8);
        set_pass(6'h11, 32'd700200);
        check("R3 zero capture retried", rd_cnt, 9);
        inject(2'b00, 2'b01, ID0);
        set_pass(6'h11, 32'd700300);
        check("R3 capture read after nonzero", rd_cnt, 10);
        set_pass(6'h11, 32'd700400);
        check("R4 kept id not re-read", rd_cnt, 10);
        check("R7 no write before window", wr_cnt, 4);
        finish_run();
    end

endmodule